// File: doc/BRIEF.md
# Bus Master Transfer Timeout Sequencer

This block runs one bus-master transfer at a time for a boot-loader peripheral that sits on an asynchronous, handshake-driven system bus. A local one-cycle request picks one of two transfer kinds: a plain data transfer or a level-1 interrupt transfer. The block then waits for the bus controller to grant the cycle. On the grant it drives its online line, which enables the bus drivers. It then counts the slave's data acknowledges. The second acknowledge makes it emit a one-cycle end-of-transfer pulse, and online stays high until that acknowledge is withdrawn.

A timer starts when the bus strobe rises. If no acknowledge arrives within the timeout window, or if the controller raises its quit line, the block drops online and aborts. In a plain data transfer the abort lasts two cycles and covers the cycle in which the pending state is wiped. In an interrupt transfer the abort follows the controller's quit-acknowledge handshake. Until the state has been cleared, no new request is taken.

Top module: `busXferSeq`

## Requirements
- R1: After reset, online is 0, onlineN is 1, abort is 0 and endPulse is 0.
- R2: Every bus input (grant, strobe, ack, quit, quitAck) passes through a two-flop synchroniser. Once a request (directReq or intReq high for one cycle while idle) has been accepted, a rising grant raises online, and lowers onlineN, 3 clock edges after the grant changes.
- R3: The first rising ack of a transfer produces no endPulse. The second rising ack produces endPulse high for exactly one cycle, 3 edges after the ack rises.
- R4: After the second ack, online stays high until ack falls, and it drops 3 edges after the fall.
- R5: In a plain data transfer, a rising quit while a transfer is pending drops online and raises abort 3 edges later. Abort then stays high for exactly 2 cycles.
- R6: If TIMEOUT_CYCLES (default 100) cycles pass after a synchronised rising strobe with no rising ack, the block aborts in the same way as on quit. In a plain data transfer abort appears TIMEOUT_CYCLES+3 edges after the strobe changes.
- R7: In an interrupt transfer, an abort cause drops online but leaves abort low. Abort then rises 3 edges after quitAck goes high and falls 3 edges after quitAck goes low, so it lasts as many cycles as quitAck was held.
- R8: A request that arrives while an abort is in progress is ignored. A later grant does not raise online.
- R9: A rising ack that arrives before the timeout stops the timer, and no abort follows, however long the transfer then lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| directReq | input | 1 | Synchronous request for a plain data transfer |
| intReq | input | 1 | Synchronous request for a level-1 interrupt transfer |
| grant | input | 1 | Asynchronous bus grant from the controller |
| strobe | input | 1 | Asynchronous bus strobe; its rise starts the timer |
| ack | input | 1 | Asynchronous slave data acknowledge |
| quit | input | 1 | Asynchronous quit from the controller |
| quitAck | input | 1 | Asynchronous quit-acknowledge from the controller |
| online | output | 1 | Online / drive enable, active high |
| onlineN | output | 1 | Companion online line, active low |
| endPulse | output | 1 | One-cycle end-of-transfer pulse |
| abort | output | 1 | Abort output, active high |

## Verification
Every bus-side input takes three clock edges to reach an output: two synchroniser flops, then the registered output, which decodes the next state. The bench therefore drives inputs on the falling edge and samples exactly three falling edges later. It also checks one falling edge earlier, where a result must not appear too soon. A timeout result is due TIMEOUT_CYCLES+3 edges after the strobe changes. The bench samples abort one edge before that point and again at it. Abort lengths are counted sample by sample and compared with a bench function of the transfer kind and of how long quitAck was held.

// File: rtl/busXferSeqPkg.sv
package busXferSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ONLINE,
    ST_HOLD,
    ST_ABT_D,
    ST_ABT_I_WAIT,
    ST_ABT_I_ON,
    ST_CLR
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDirect;
    logic loadInt;
    logic armTimer;
    logic disarmTimer;
    logic bumpAck;
    logic clearAll;
  } ctrlStrobeT;

  // conditions from datapath to control
  typedef struct packed {
    logic grantRise;
    logic strobeRise;
    logic ackRise;
    logic ackFall;
    logic quitRise;
    logic quitAckLvl;
    logic quitAckFall;
    logic timeoutHit;
    logic ackLast;
    logic pending;
    logic isInt;
  } dpStatusT;

endpackage

// File: rtl/busXferSync.sv
module busXferSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/busXferDatapath.sv
module busXferDatapath
  import busXferSeqPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100,
  parameter int ACKS_TO_END    = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] busIn,   // {quitAck, quit, ack, strobe, grant}
  input  ctrlStrobeT strb,
  output dpStatusT   stat
);
  localparam int NUM_IN = 5;
  localparam int CNT_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int ACK_W  = $clog2(ACKS_TO_END + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACKS_TO_END - 1);

  logic [NUM_IN-1:0] syncVal, prevVal, riseVec, fallVec;
  logic [CNT_W-1:0]  timerCnt;
  logic              timerArmed;
  logic [ACK_W-1:0]  ackCnt;
  logic              pendFlag, intFlag;

  for (genvar i = 0; i < NUM_IN; i++) begin : gSync
    busXferSync #(.STAGES(SYNC_STAGES)) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (busIn[i]),
      .dout(syncVal[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= syncVal;
  end

  assign riseVec = syncVal & ~prevVal;
  assign fallVec = ~syncVal & prevVal;

  // timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerArmed <= 1'b0;
      timerCnt   <= '0;
    end else if (strb.clearAll || strb.disarmTimer) begin
      timerArmed <= 1'b0;
      timerCnt   <= '0;
    end else if (strb.armTimer) begin
      timerArmed <= 1'b1;
      timerCnt   <= '0;
    end else if (timerArmed && timerCnt != CNT_LAST) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  // acknowledge counter and transfer flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackCnt   <= '0;
      pendFlag <= 1'b0;
      intFlag  <= 1'b0;
    end else if (strb.clearAll) begin
      ackCnt   <= '0;
      pendFlag <= 1'b0;
      intFlag  <= 1'b0;
    end else begin
      if (strb.bumpAck) ackCnt <= ackCnt + 1'b1;
      if (strb.loadDirect || strb.loadInt) begin
        pendFlag <= 1'b1;
        intFlag  <= strb.loadInt;
      end
    end
  end

  assign stat.grantRise   = riseVec[0];
  assign stat.strobeRise  = riseVec[1];
  assign stat.ackRise     = riseVec[2];
  assign stat.ackFall     = fallVec[2];
  assign stat.quitRise    = riseVec[3];
  assign stat.quitAckLvl  = syncVal[4];
  assign stat.quitAckFall = fallVec[4];
  assign stat.timeoutHit  = timerArmed && (timerCnt == CNT_LAST);
  assign stat.ackLast     = (ackCnt == ACK_LAST);
  assign stat.pending     = pendFlag;
  assign stat.isInt       = intFlag;

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    timerCnt <= CNT_LAST) else $error("timer out of range"); // R6
  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stat.timeoutHit |=> !stat.timeoutHit) else $error("timeout repeated"); // R6
  AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.disarmTimer |=> !stat.timeoutHit) else $error("timer kept running"); // R9
endmodule

// File: rtl/busXferCtrl.sv
module busXferCtrl
  import busXferSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       directReq,
  input  logic       intReq,
  input  dpStatusT   stat,
  output ctrlStrobeT strb,
  output logic       onlineQ,
  output logic       abortQ,
  output logic       endQ
);
  seqStateT state, nextState;
  logic     abortEvt, inXfer;

  assign inXfer   = (state == ST_WAIT) || (state == ST_ONLINE);
  assign abortEvt = inXfer && stat.pending && (stat.quitRise || stat.timeoutHit);

  always_comb begin
    nextState = state;
    strb      = '0;
    if (inXfer) begin
      if (abortEvt)
        strb.disarmTimer = 1'b1;
      else if (state == ST_ONLINE && stat.ackRise)
        strb.disarmTimer = 1'b1;
      else if (stat.strobeRise)
        strb.armTimer = 1'b1;
    end
    unique case (state)
      ST_IDLE: begin
        if (directReq) begin
          strb.loadDirect = 1'b1;
          nextState       = ST_WAIT;
        end else if (intReq) begin
          strb.loadInt = 1'b1;
          nextState    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (abortEvt)            nextState = stat.isInt ? ST_ABT_I_WAIT : ST_ABT_D;
        else if (stat.grantRise) nextState = ST_ONLINE;
      end
      ST_ONLINE: begin
        if (abortEvt) nextState = stat.isInt ? ST_ABT_I_WAIT : ST_ABT_D;
        else if (stat.ackRise) begin
          if (stat.ackLast) nextState    = ST_HOLD;
          else              strb.bumpAck = 1'b1;
        end
      end
      ST_HOLD: begin
        if (stat.ackFall) begin
          strb.clearAll = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_ABT_D:      nextState = ST_CLR;
      ST_ABT_I_WAIT: if (stat.quitAckLvl) nextState = ST_ABT_I_ON;
      ST_ABT_I_ON:   if (stat.quitAckFall) nextState = ST_CLR;
      ST_CLR: begin
        strb.clearAll = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      onlineQ <= 1'b0;
      abortQ  <= 1'b0;
      endQ    <= 1'b0;
    end else begin
      state   <= nextState;
      onlineQ <= (nextState == ST_ONLINE) || (nextState == ST_HOLD);
      abortQ  <= (nextState == ST_ABT_D) || (nextState == ST_ABT_I_ON) ||
                 (nextState == ST_CLR && !stat.isInt);
      endQ    <= (state == ST_ONLINE) && !abortEvt && stat.ackRise && stat.ackLast;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!onlineQ && !abortQ)) else $error("idle not quiet"); // R1
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    endQ |=> !endQ) else $error("end pulse too long"); // R3
  AST_HOLD_ONLINE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> onlineQ) else $error("online lost in hold"); // R4
  AST_ONLINE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(onlineQ && abortQ)) else $error("online with abort"); // R5
  AST_DIRECT_ABORT_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (abortQ && state == ST_ABT_D) |=> abortQ) else $error("direct abort short"); // R5
  AST_INT_ABORT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ABT_I_WAIT) |-> !abortQ) else $error("abort before quitAck"); // R7
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLR) |=> !stat.pending) else $error("pending not cleared"); // R8
endmodule

// File: rtl/busXferSeq.sv
module busXferSeq
  import busXferSeqPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100,
  parameter int ACKS_TO_END    = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic directReq,
  input  logic intReq,
  input  logic grant,
  input  logic strobe,
  input  logic ack,
  input  logic quit,
  input  logic quitAck,
  output logic online,
  output logic onlineN,
  output logic endPulse,
  output logic abort
);
  ctrlStrobeT strb;
  dpStatusT   stat;
  logic       onlineQ;

  busXferDatapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .ACKS_TO_END   (ACKS_TO_END),
    .SYNC_STAGES   (SYNC_STAGES)
  ) uDp (
    .clk  (clk),
    .rstN (rstN),
    .busIn({quitAck, quit, ack, strobe, grant}),
    .strb (strb),
    .stat (stat)
  );

  busXferCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .directReq(directReq),
    .intReq   (intReq),
    .stat     (stat),
    .strb     (strb),
    .onlineQ  (onlineQ),
    .abortQ   (abort),
    .endQ     (endPulse)
  );

  assign online  = onlineQ;
  assign onlineN = ~onlineQ;
endmodule

// File: tb/busXferSeq_test.sv
module busXferSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 100;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic directReq = 1'b0, intReq = 1'b0, grant = 1'b0, strobe = 1'b0;
  logic ack = 1'b0, quit = 1'b0, quitAck = 1'b0;
  logic online, onlineN, endPulse, abort;
  int   checks = 0;
  int   errors = 0;

  busXferSeq #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rstN(rstN), .directReq(directReq), .intReq(intReq),
    .grant(grant), .strobe(strobe), .ack(ack), .quit(quit), .quitAck(quitAck),
    .online(online), .onlineN(onlineN), .endPulse(endPulse), .abort(abort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected abort length from the requirements
  function automatic int expAbortLen(input bit isInt, input int qaHold);
    return isInt ? qaHold : 2;
  endfunction

  // lead: edges from cause to when abort (direct) or abort-wait (interrupt) applies
  task automatic abortPhase(input bit isInt, input int lead, input int qaHold);
    int cnt = 0;
    if (!isInt) begin
      for (int i = 1; i <= lead + 6; i++) begin
        @(negedge clk);
        if (i == lead - 1) chk("R5 abort early", abort, 0);
        if (i == lead) chk("R5 online drop", online, 0);
        if (abort) cnt++;
        directReq = (i == lead);   // R8: request during abort
      end
      chk("R5 direct abort length", cnt, expAbortLen(1'b0, qaHold));
    end else begin
      step(lead);
      chk("R7 online drop", online, 0);
      chk("R7 abort waits quitAck", abort, 0);
      intReq = 1'b1; step(1); intReq = 1'b0;   // R8: request during abort
      quitAck = 1'b1;
      for (int i = 1; i <= qaHold + 6; i++) begin
        @(negedge clk);
        if (i == LAT - 1) chk("R7 abort early", abort, 0);
        if (abort) cnt++;
        if (i == qaHold) quitAck = 1'b0;
      end
      chk("R7 interrupt abort length", cnt, expAbortLen(1'b1, qaHold));
    end
    directReq = 1'b0;
    grant = 1'b0; strobe = 1'b0; quit = 1'b0;
    step(4);
    grant = 1'b1; step(LAT + 1);
    chk("R8 request ignored", online, 0);
    grant = 1'b0; step(4);
  endtask

  // outcome: 0 complete, 1 quit, 2 timeout
  task automatic xfer(input bit isInt, input int outcome, input int dly, input int hold);
    if (isInt) intReq = 1'b1; else directReq = 1'b1;
    step(1);
    intReq = 1'b0; directReq = 1'b0;
    grant = 1'b1;
    step(LAT - 1);
    chk("R2 online early", online, 0);
    step(1);
    chk("R2 online", online, 1);
    chk("R2 onlineN", onlineN, 0);
    case (outcome)
      0: begin
        strobe = 1'b1; step(dly);
        ack = 1'b1; step(LAT);
        chk("R3 no end on first ack", endPulse, 0);
        ack = 1'b0; step(LAT);
        ack = 1'b1; step(LAT - 1);
        chk("R3 end early", endPulse, 0);
        step(1);
        chk("R3 end pulse", endPulse, 1);
        chk("R4 online at end", online, 1);
        step(1);
        chk("R3 end one cycle", endPulse, 0);
        step(hold);
        chk("R4 online held", online, 1);
        ack = 1'b0; step(LAT - 1);
        chk("R4 online before drop", online, 1);
        step(1);
        chk("R4 online drop", online, 0);
        chk("R9 no abort", abort, 0);
        grant = 1'b0; strobe = 1'b0; step(4);
      end
      1: begin
        quit = 1'b1;
        abortPhase(isInt, LAT, hold);
      end
      default: begin
        strobe = 1'b1;
        step(TMO + LAT - 1);
        chk("R6 abort not before timeout", abort, 0);
        abortPhase(isInt, 1, hold);
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    chk("R1 online reset", online, 0);
    chk("R1 onlineN reset", onlineN, 1);
    chk("R1 abort reset", abort, 0);
    chk("R1 end reset", endPulse, 0);
    rstN = 1'b1;
    step(2);

    // directed corner cases
    xfer(1'b0, 0, 1, 2);
    xfer(1'b1, 0, 4, 0);
    xfer(1'b0, 1, 1, 1);
    xfer(1'b1, 1, 1, 1);
    xfer(1'b1, 1, 1, 5);
    xfer(1'b0, 2, 1, 1);
    xfer(1'b1, 2, 1, 3);

    // R9: ack just before the timeout stops the timer
    directReq = 1'b1; step(1); directReq = 1'b0;
    grant = 1'b1; step(LAT);
    strobe = 1'b1; step(TMO - 5);
    ack = 1'b1; step(TMO + 10);
    chk("R9 ack stops timer", abort, 0);
    chk("R9 still online", online, 1);
    ack = 1'b0; step(LAT);
    ack = 1'b1; step(LAT);
    chk("R9 end after late first ack", endPulse, 1);
    ack = 1'b0; step(LAT);
    chk("R9 online drop", online, 0);
    grant = 1'b0; strobe = 1'b0; step(4);

    // constrained random transfers
    for (int n = 0; n < 40; n++) begin
      int oc;
      oc = int'($urandom_range(0, 9));
      oc = (oc < 5) ? 0 : (oc < 9) ? 1 : 2;
      xfer(1'($urandom_range(0, 1)), oc, int'($urandom_range(1, 8)),
           int'($urandom_range(1, 6)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule